// File: doc/BRIEF.md
# Chainable Serial Codec Slot Port

This block is the slave end of a synchronous serial link between a host and a codec front end. The host supplies the bit clock, a frame sync and serial data. In each frame the port shifts one 16-bit word out and one 16-bit word in, most significant bit first. Each frame is either a data frame or a control frame. A data frame carries a receive sample out and a transmit sample in. A control frame reads or writes a small register bank inside the port.

The port supports two ways of scheduling control frames. With hardware scheduling, every data frame is followed by a control frame. With software scheduling, the least significant transmit bit serves as a request for a control frame. Several ports can share one long frame. Each port passes a delayed sync to the next port, so the next port takes the 16-bit slot that follows its own. When the chain strap is set, software requests are ignored and hardware scheduling applies.

Top module: `codec_serial_port`

## Requirements
- R1: In its own slot the port drives `sdout_oe` high and sends 16 bits MSB first on `sdout`, changing on the falling clock edge. The first bit appears on the falling edge at which `fs_in` is high. In a data frame the word sent is `rx_word`. Outside the slot `sdout_oe` is low.
- R2: `sdin` is sampled MSB first on rising edges, starting with the edge that sees `fs_in` high. In the clock cycle after the 16th bit is captured, exactly one strobe is high for one cycle: `tx_valid` for a data frame or `ctl_valid` for a control frame.
- R3: In software mode (`chain_en`=0 and register 1 bit 0 = 0), bit 0 of a data word is a request flag and `tx_word` bit 0 reads 0. A flag of 1 makes the next frame a control frame; a flag of 0 keeps it a data frame.
- R4: When register 1 bit 0 is 1, all 16 bits appear on `tx_word` and frames alternate between data and control. The first frame after reset is a data frame in every mode.
- R5: With `chain_en`=1 the request flag has no effect on scheduling. All 16 bits pass to `tx_word`, and frames alternate as in R4.
- R6: A control word uses bit 15 for read (1) or write (0), bits 14..8 for the register address and bits 7..0 for write data. A write updates the addressed register and sets `ctl_data` to the written value. A read sets `ctl_data` to the register value. Registers reset to 0. Addresses at or above the register count read 0, and writes to them change nothing.
- R7: During a control frame, `sdout` sends the value of the most recent read in bits 7..0 and zeros in bits 15..8. That value is 0 after reset.
- R8: `fs_out` is high for exactly one clock cycle: the cycle after the rising edge that captures the local bit 0. This is 16 clocks after the local sync edge, so the next port's bit 15 falls in that cycle.
- R9: A port whose `fs_in` is driven by another port's `fs_out` handles the following 16-bit slot in the same way as R1 to R7.
- R10: `rate_err` goes high and stays high when the number of clocks between two consecutive syncs is below 96 or above 256. The first sync after reset is not checked. Frames are still processed normally.
- R11: During reset `sdout_oe`, `fs_out`, `tx_valid`, `ctl_valid` and `rate_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial bit clock from the host |
| rst_n | input | 1 | Asynchronous active-low reset |
| chain_en | input | 1 | Chained/slave strap; forces hardware control-frame scheduling |
| fs_in | input | 1 | Late-type frame sync, high during the slot's first bit |
| sdin | input | 1 | Serial transmit/control data in |
| rx_word | input | 16 | Receive sample to send in data frames |
| sdout | output | 1 | Serial data out |
| sdout_oe | output | 1 | High while this port owns the output line |
| fs_out | output | 1 | Forwarded late-type sync for the next port |
| tx_word | output | 16 | Transmit word captured in a data frame |
| tx_valid | output | 1 | One-cycle strobe for `tx_word` |
| ctl_valid | output | 1 | One-cycle strobe for a finished control frame |
| ctl_data | output | 8 | Written value or read result of that control frame |
| rate_err | output | 1 | Sticky sync-period range error |

## Verification
The bench builds two ports with the default parameters: 16-bit slots, four 8-bit registers behind a 7-bit address, and a period window of 96 to 256 clocks. The second port is chained from the first. With four registers, random addresses up to 5 reach both mapped and unmapped registers. With the chain, one 32-bit frame checks the slot hand-off, the one-cycle forwarded sync and the output-enable windows of both ports. With the window limits at their defaults, the bench can drive periods of exactly 95, 96, 256 and 257 clocks.

// File: rtl/codec_port_pkg.sv
`timescale 1ns/1ps
package codec_port_pkg;
   typedef enum logic {
      FRM_DATA = 1'b0,
      FRM_CTL  = 1'b1
   } frame_kind_e;

   function automatic int unsigned count_width(input int unsigned limit);
      return $clog2(limit + 1);
   endfunction
endpackage

// File: rtl/cp_rx_shift.sv
`timescale 1ns/1ps
module cp_rx_shift #(
   parameter int unsigned WORD_W     = 16,
   parameter int unsigned MIN_PER    = 96,
   parameter int unsigned MAX_PER    = 256,
   parameter bit          CHECK_RATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fs_in,
   input  logic              sdin,
   output logic              word_done,
   output logic [WORD_W-1:0] word,
   output logic              fs_fwd,
   output logic              rate_err
);
   localparam int unsigned CNT_W = codec_port_pkg::count_width(WORD_W);
   localparam int unsigned PER_W = codec_port_pkg::count_width(MAX_PER + 1);

   logic [WORD_W-1:0] sr_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              active_q;
   logic              done_q;

   // capture on rising edges, sync high marks the slot's first bit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q     <= '0;
         cnt_q    <= '0;
         active_q <= 1'b0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (fs_in) begin
            sr_q     <= {{(WORD_W-1){1'b0}}, sdin};
            cnt_q    <= CNT_W'(1);
            active_q <= 1'b1;
         end else if (active_q) begin
            sr_q  <= {sr_q[WORD_W-2:0], sdin};
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_W'(WORD_W - 1)) begin
               active_q <= 1'b0;
               done_q   <= 1'b1;
            end
         end
      end
   end

   assign word_done = done_q;
   assign word      = sr_q;
   // next slot begins right after local bit 0: late-type forward
   assign fs_fwd    = done_q;

   generate
      if (CHECK_RATE) begin : g_rate
         logic [PER_W-1:0] per_q;
         logic             seen_q;
         logic             err_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               per_q  <= '0;
               seen_q <= 1'b0;
               err_q  <= 1'b0;
            end else if (fs_in) begin
               if (seen_q && (per_q < PER_W'(MIN_PER) || per_q > PER_W'(MAX_PER)))
                  err_q <= 1'b1;
               per_q  <= PER_W'(1);
               seen_q <= 1'b1;
            end else if (per_q <= PER_W'(MAX_PER)) begin
               per_q <= per_q + 1'b1;
            end
         end
         assign rate_err = err_q;
      end else begin : g_norate
         assign rate_err = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/cp_tx_shift.sv
`timescale 1ns/1ps
module cp_tx_shift #(
   parameter int unsigned WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fs_in,
   input  logic [WORD_W-1:0] load_word,
   output logic              sdout,
   output logic              sdout_oe
);
   localparam int unsigned CNT_W = codec_port_pkg::count_width(WORD_W);

   logic [WORD_W-1:0] sh_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              bit_q;
   logic              oe_q;

   // launch on falling edges so the host samples a settled bit
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= '0;
         cnt_q <= '0;
         bit_q <= 1'b0;
         oe_q  <= 1'b0;
      end else if (fs_in) begin
         sh_q  <= {load_word[WORD_W-2:0], 1'b0};
         bit_q <= load_word[WORD_W-1];
         cnt_q <= CNT_W'(1);
         oe_q  <= 1'b1;
      end else if (oe_q) begin
         if (cnt_q == CNT_W'(WORD_W)) begin
            oe_q  <= 1'b0;
            bit_q <= 1'b0;
         end else begin
            bit_q <= sh_q[WORD_W-1];
            sh_q  <= {sh_q[WORD_W-2:0], 1'b0};
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign sdout    = bit_q;
   assign sdout_oe = oe_q;
endmodule

// File: rtl/cp_ctl_sched.sv
`timescale 1ns/1ps
module cp_ctl_sched #(
   parameter int unsigned WORD_W     = 16,
   parameter int unsigned REG_W      = 8,
   parameter int unsigned ADDR_W     = 7,
   parameter int unsigned NUM_REGS   = 4,
   parameter int unsigned HWCTL_ADDR = 1,
   parameter int unsigned HWCTL_BIT  = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chain_en,
   input  logic              word_done,
   input  logic [WORD_W-1:0] word,
   output logic              is_ctl,
   output logic              hw_mode,
   output logic [WORD_W-1:0] resp_word,
   output logic [WORD_W-1:0] tx_word,
   output logic              tx_valid,
   output logic              ctl_valid,
   output logic [REG_W-1:0]  ctl_data
);
   import codec_port_pkg::*;

   localparam int unsigned RD_POS  = WORD_W - 1;
   localparam int unsigned ADR_TOP = WORD_W - 2;

   frame_kind_e        kind_q;
   logic [REG_W-1:0]   reg_q [NUM_REGS];
   logic [REG_W-1:0]   hold_q;
   logic [REG_W-1:0]   rd_val;
   logic               op_rd;
   logic [ADDR_W-1:0]  op_addr;
   logic [REG_W-1:0]   op_data;
   logic               sched_hw;

   assign op_rd   = word[RD_POS];
   assign op_addr = word[ADR_TOP -: ADDR_W];
   assign op_data = word[REG_W-1:0];

   always_comb begin
      rd_val = '0;
      for (int i = 0; i < NUM_REGS; i++)
         if (op_addr == ADDR_W'(i)) rd_val = reg_q[i];
   end

   assign hw_mode  = reg_q[HWCTL_ADDR][HWCTL_BIT];
   assign sched_hw = hw_mode | chain_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind_q <= FRM_DATA;
         hold_q <= '0;
         for (int i = 0; i < NUM_REGS; i++) reg_q[i] <= '0;
      end else if (word_done) begin
         if (kind_q == FRM_CTL) begin
            kind_q <= FRM_DATA;
            if (op_rd) begin
               hold_q <= rd_val;
            end else begin
               for (int i = 0; i < NUM_REGS; i++)
                  if (op_addr == ADDR_W'(i)) reg_q[i] <= op_data;
            end
         end else begin
            // request flag only counts when scheduling is in software hands
            kind_q <= (sched_hw || word[0]) ? FRM_CTL : FRM_DATA;
         end
      end
   end

   assign is_ctl    = (kind_q == FRM_CTL);
   assign resp_word = {{(WORD_W-REG_W){1'b0}}, hold_q};
   assign tx_word   = sched_hw ? word : {word[WORD_W-1:1], 1'b0};
   assign tx_valid  = word_done && !is_ctl;
   assign ctl_valid = word_done && is_ctl;
   assign ctl_data  = op_rd ? rd_val : op_data;
endmodule

// File: rtl/codec_serial_port.sv
`timescale 1ns/1ps
module codec_serial_port #(
   parameter int unsigned WORD_W     = 16,
   parameter int unsigned REG_W      = 8,
   parameter int unsigned ADDR_W     = 7,
   parameter int unsigned NUM_REGS   = 4,
   parameter int unsigned HWCTL_ADDR = 1,
   parameter int unsigned HWCTL_BIT  = 0,
   parameter int unsigned MIN_PER    = 96,
   parameter int unsigned MAX_PER    = 256,
   parameter bit          CHECK_RATE = 1'b1
) (
   input  logic              sclk,
   input  logic              rst_n,
   input  logic              chain_en,
   input  logic              fs_in,
   input  logic              sdin,
   input  logic [WORD_W-1:0] rx_word,
   output logic              sdout,
   output logic              sdout_oe,
   output logic              fs_out,
   output logic [WORD_W-1:0] tx_word,
   output logic              tx_valid,
   output logic              ctl_valid,
   output logic [REG_W-1:0]  ctl_data,
   output logic              rate_err
);
   generate
      if (1 + ADDR_W + REG_W != WORD_W) begin : g_bad_fields
         $error("control word fields do not fill WORD_W");
      end
      if (NUM_REGS < 1 || NUM_REGS > (1 << ADDR_W)) begin : g_bad_regs
         $error("NUM_REGS out of address range");
      end
      if (HWCTL_ADDR >= NUM_REGS || HWCTL_BIT >= REG_W) begin : g_bad_hwctl
         $error("hardware-control bit outside register bank");
      end
      if (MIN_PER <= WORD_W + 1 || MAX_PER < MIN_PER) begin : g_bad_period
         $error("sync period window invalid");
      end
   endgenerate

   logic              done;
   logic [WORD_W-1:0] word;
   logic              is_ctl;
   logic              hw_mode;
   logic [WORD_W-1:0] resp_word;
   logic [WORD_W-1:0] load_word;

   cp_rx_shift #(
      .WORD_W(WORD_W), .MIN_PER(MIN_PER), .MAX_PER(MAX_PER), .CHECK_RATE(CHECK_RATE)
   ) rx_i (
      .clk(sclk), .rst_n(rst_n), .fs_in(fs_in), .sdin(sdin),
      .word_done(done), .word(word), .fs_fwd(fs_out), .rate_err(rate_err)
   );

   cp_ctl_sched #(
      .WORD_W(WORD_W), .REG_W(REG_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS),
      .HWCTL_ADDR(HWCTL_ADDR), .HWCTL_BIT(HWCTL_BIT)
   ) ctl_i (
      .clk(sclk), .rst_n(rst_n), .chain_en(chain_en), .word_done(done), .word(word),
      .is_ctl(is_ctl), .hw_mode(hw_mode), .resp_word(resp_word), .tx_word(tx_word),
      .tx_valid(tx_valid), .ctl_valid(ctl_valid), .ctl_data(ctl_data)
   );

   assign load_word = is_ctl ? resp_word : rx_word;

   cp_tx_shift #(.WORD_W(WORD_W)) tx_i (
      .clk(sclk), .rst_n(rst_n), .fs_in(fs_in), .load_word(load_word),
      .sdout(sdout), .sdout_oe(sdout_oe)
   );
endmodule

// File: rtl/codec_serial_port_chk.sv
`timescale 1ns/1ps
module codec_serial_port_chk (
   input logic sclk,
   input logic rst_n,
   input logic fs_in,
   input logic chain_en,
   input logic sdout_oe,
   input logic fs_out,
   input logic tx_valid,
   input logic tx_lsb,
   input logic ctl_valid,
   input logic rate_err,
   input logic hw_mode
);
   logic last_data_q;

   always_ff @(posedge sclk or negedge rst_n) begin
      if (!rst_n)         last_data_q <= 1'b0;
      else if (tx_valid)  last_data_q <= 1'b1;
      else if (ctl_valid) last_data_q <= 1'b0;
   end

   a_r8_fs_out_single: assert property (@(posedge sclk) disable iff (!rst_n)
      fs_out |=> !fs_out);

   a_r8_fs_out_at_word_end: assert property (@(posedge sclk) disable iff (!rst_n)
      fs_out |-> (tx_valid || ctl_valid));

   a_r2_one_strobe: assert property (@(posedge sclk) disable iff (!rst_n)
      !(tx_valid && ctl_valid));

   a_r3_flag_masked: assert property (@(posedge sclk) disable iff (!rst_n)
      (tx_valid && !chain_en && !hw_mode) |-> !tx_lsb);

   a_r4_ctl_follows_data: assert property (@(posedge sclk) disable iff (!rst_n)
      ctl_valid |-> last_data_q);

   a_r10_err_sticky: assert property (@(posedge sclk) disable iff (!rst_n)
      rate_err |=> rate_err);

   a_r1_oe_starts_on_sync: assert property (@(posedge sclk) disable iff (!rst_n)
      $rose(sdout_oe) |-> fs_in);
endmodule

bind codec_serial_port codec_serial_port_chk chk_i (
   .sclk(sclk), .rst_n(rst_n), .fs_in(fs_in), .chain_en(chain_en),
   .sdout_oe(sdout_oe), .fs_out(fs_out), .tx_valid(tx_valid), .tx_lsb(tx_word[0]),
   .ctl_valid(ctl_valid), .rate_err(rate_err), .hw_mode(hw_mode)
);

// File: tb/codec_serial_port_tb_top.sv
`timescale 1ns/1ps
module codec_serial_port_tb_top;
   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst_n = 1'b0, chain_en = 1'b0, fs_in = 1'b0, sdin = 1'b0;
   logic [15:0] rxw_a = '0, rxw_b = '0;
   logic sdo_a, oe_a, fso_a, txv_a, cv_a, err_a;
   logic sdo_b, oe_b, fso_b, txv_b, cv_b, err_b;
   logic [15:0] txw_a, txw_b;
   logic [7:0]  cd_a, cd_b;
   logic sdout_bus;

   assign sdout_bus = oe_a ? sdo_a : (oe_b ? sdo_b : 1'b0);

   codec_serial_port dut_i (
      .sclk(clk), .rst_n(rst_n), .chain_en(chain_en), .fs_in(fs_in), .sdin(sdin),
      .rx_word(rxw_a), .sdout(sdo_a), .sdout_oe(oe_a), .fs_out(fso_a),
      .tx_word(txw_a), .tx_valid(txv_a), .ctl_valid(cv_a), .ctl_data(cd_a),
      .rate_err(err_a));

   codec_serial_port dut_b_i (
      .sclk(clk), .rst_n(rst_n), .chain_en(chain_en), .fs_in(fso_a), .sdin(sdin),
      .rx_word(rxw_b), .sdout(sdo_b), .sdout_oe(oe_b), .fs_out(fso_b),
      .tx_word(txw_b), .tx_valid(txv_b), .ctl_valid(cv_b), .ctl_data(cd_b),
      .rate_err(err_b));

   int errors = 0, checks = 0;
   bit finished = 1'b0;

   // bench reference model, one entry per port
   logic       m_ctl  [2];
   logic [7:0] m_reg  [2][4];
   logic [7:0] m_hold [2];

   logic        got_tx [2], got_ctl [2];
   int          at_tx [2], at_ctl [2];
   logic [15:0] gw [2];
   logic [7:0]  gc [2];

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic sched_hw(input int d);
      return chain_en | m_reg[d][1][0];
   endfunction

   task automatic model_reset();
      for (int d = 0; d < 2; d++) begin
         m_ctl[d] = 1'b0;
         m_hold[d] = '0;
         for (int r = 0; r < 4; r++) m_reg[d][r] = '0;
      end
   endtask

   task automatic apply_reset();
      rst_n = 1'b0; fs_in = 1'b0; sdin = 1'b0;
      repeat (3) @(posedge clk);
      #2;
      model_reset();
      // R11: reset state on both ports
      chk({oe_a, fso_a, txv_a, cv_a, err_a} == 5'b0, "R11 reset port A", {oe_a, fso_a, txv_a, cv_a, err_a}, 0);
      chk({oe_b, fso_b, txv_b, cv_b, err_b} == 5'b0, "R11 reset port B", {oe_b, fso_b, txv_b, cv_b, err_b}, 0);
      rst_n = 1'b1;
   endtask

   function automatic logic [15:0] gen_word(input int d);
      logic [15:0] w;
      if (m_ctl[d]) w = {1'($urandom), 7'($urandom % 6), 8'($urandom)};
      else begin
         w = 16'($urandom);
         w[0] = ($urandom % 3) == 0;
      end
      return w;
   endfunction

   task automatic check_slot(input int d, input logic [15:0] w, input logic [15:0] o);
      logic [15:0] exp_out, expw;
      logic [7:0]  rv, expc;
      int          exp_at;
      string       tag;
      exp_at  = 16 + 16 * d;
      exp_out = m_ctl[d] ? {8'h00, m_hold[d]} : (d == 0 ? rxw_a : rxw_b);
      tag = m_ctl[d] ? "R7 read-back word on sdout" : (d == 1 ? "R9 chained slot sdout" : "R1 data word on sdout");
      chk(o === exp_out, tag, o, exp_out);
      if (!m_ctl[d]) begin
         expw = sched_hw(d) ? w : {w[15:1], 1'b0};
         chk(got_tx[d] && !got_ctl[d] && at_tx[d] == exp_at, "R2 data strobe timing", at_tx[d], exp_at);
         tag = chain_en ? "R5 flag passed as data" : (sched_hw(d) ? "R4 full 16-bit word" : "R3 flag bit forced low");
         chk(gw[d] === expw, tag, gw[d], expw);
         m_ctl[d] = sched_hw(d) | w[0];
      end else begin
         rv   = (w[14:8] < 4) ? m_reg[d][w[9:8]] : 8'h00;
         expc = w[15] ? rv : w[7:0];
         chk(got_ctl[d] && !got_tx[d] && at_ctl[d] == exp_at, "R6 control strobe timing", at_ctl[d], exp_at);
         chk(gc[d] === expc, "R6 control result", gc[d], expc);
         if (w[15]) m_hold[d] = rv;
         else if (w[14:8] < 4) m_reg[d][w[9:8]] = w[7:0];
         m_ctl[d] = 1'b0;
      end
   endtask

   task automatic run_frame(input logic [15:0] wa, input logic [15:0] wb, input int period);
      logic [31:0] bits, ob;
      int bad_oe, bad_fso;
      bits = {wa, wb}; ob = '0; bad_oe = 0; bad_fso = 0;
      for (int d = 0; d < 2; d++) begin
         got_tx[d] = 0; got_ctl[d] = 0; at_tx[d] = -1; at_ctl[d] = -1;
      end
      for (int i = 0; i < period; i++) begin
         @(posedge clk);
         #2;
         fs_in = (i == 0);
         sdin  = (i < 32) ? bits[31-i] : 1'b0;
         #13;
         if (i < 32) ob[31-i] = sdout_bus;
         if (i < 34) begin
            if (oe_a !== (i < 16)) bad_oe++;
            if (oe_b !== (i >= 16 && i < 32)) bad_oe++;
            if (fso_a !== (i == 16)) bad_fso++;
            if (fso_b !== (i == 32)) bad_fso++;
         end
         if (txv_a) begin got_tx[0] = 1; at_tx[0] = i; gw[0] = txw_a; end
         if (cv_a)  begin got_ctl[0] = 1; at_ctl[0] = i; gc[0] = cd_a; end
         if (txv_b) begin got_tx[1] = 1; at_tx[1] = i; gw[1] = txw_b; end
         if (cv_b)  begin got_ctl[1] = 1; at_ctl[1] = i; gc[1] = cd_b; end
      end
      chk(bad_oe == 0, "R1 output enable window", bad_oe, 0);
      chk(bad_fso == 0, "R8 forwarded sync single pulse", bad_fso, 0);
      check_slot(0, wa, ob[31:16]);
      check_slot(1, wb, ob[15:0]);
   endtask

   task automatic rand_frame(input int period);
      rxw_a = 16'($urandom);
      rxw_b = 16'($urandom);
      run_frame(gen_word(0), gen_word(1), period);
   endtask

   initial begin
      void'($urandom(32'h1903));
      apply_reset();
      // software mode, directed sequence on port A
      chain_en = 1'b0;
      rxw_a = 16'hC3A5; rxw_b = 16'h0F0F;
      run_frame(16'h1235, 16'h0000, 96);   // R3 request
      run_frame(16'h025A, 16'h0000, 256);  // R6 write reg 2
      run_frame(16'h0001, 16'h0000, 128);
      run_frame(16'h8200, 16'h0000, 128);  // R6 read reg 2
      run_frame(16'h7777, 16'h0000, 128);
      run_frame(16'h8500, 16'h0000, 128);  // R7 sends 5A, unmapped read gives 0
      run_frame(16'h0001, 16'h0000, 128);
      run_frame(16'h0101, 16'h0000, 128);  // R4 enable hardware scheduling
      run_frame(16'hFFFF, 16'h0000, 128);
      run_frame(16'h8100, 16'h0000, 128);
      for (int k = 0; k < 40; k++) rand_frame(96 + int'($urandom % 161));
      chain_en = 1'b1;
      for (int k = 0; k < 40; k++) rand_frame(96 + int'($urandom % 161));
      chk(err_a == 1'b0 && err_b == 1'b0, "R10 no error inside window", {err_a, err_b}, 0);
      // R10 short period
      rand_frame(95);
      rand_frame(100);
      chk(err_a == 1'b1 && err_b == 1'b1, "R10 short period flagged", {err_a, err_b}, 2'b11);
      rand_frame(120);
      chk(err_a == 1'b1, "R10 flag sticky", err_a, 1);
      // R10 first sync unchecked, long period flagged
      apply_reset();
      rxw_a = 16'h1111; rxw_b = 16'h2222;
      run_frame(16'h0003, 16'h0003, 257);  // R5 flag bit kept in chain mode
      chk(err_a == 1'b0, "R10 first sync not checked", err_a, 0);
      rand_frame(100);
      chk(err_a == 1'b1 && err_b == 1'b1, "R10 long period flagged", {err_a, err_b}, 2'b11);
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(20 * 150000);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule